// File: doc/BRIEF.md
# Bus Hold Arbiter

This block hands the system buses to an external bus master on request. The request input is registered on the rising clock edge. The arbiter then waits until the core reports that it is at a machine-cycle boundary, so a transfer already in progress always completes. At that point it raises the acknowledge output. One clock later it withdraws the output enable of the core's address, data, read, write and memory/IO lines so that the other master can drive them.

While the grant is held, the core is told to stall so that it starts no new bus cycle. Work inside the core that needs no bus is not affected. When the request is withdrawn, the acknowledge drops on a rising edge. The core's drivers are enabled again half a clock later, on the following falling edge. While reset is held, the acknowledge is low and the bus lines are floated. Reset is asserted asynchronously and released through a synchronizer.

Top module: `bus_hold_arbiter`

## Requirements
- R1: `hold_req` is registered on the rising clock edge before it is used. When the request is raised and the core is at a boundary, `hold_ack` rises at the second rising edge after the request appears, never at the first.
- R2: `hold_ack` rises only at a rising edge where `mc_boundary` was high. A request made while `mc_boundary` is low leaves `hold_ack` low until the boundary arrives.
- R3: `bus_oe` stays high for the whole clock cycle in which `hold_ack` first goes high, and falls at the next rising edge.
- R4: Without a registered request, `hold_ack` never rises and `bus_oe` stays high.
- R5: `core_stall` is high while `hold_ack` is high. It is also high in any cycle where the registered request and `mc_boundary` are both high, so the core starts no cycle at the edge where the grant begins.
- R6: After the registered request goes low, `hold_ack` falls at the next rising edge.
- R7: After `hold_ack` falls, `bus_oe` stays low until the next falling clock edge and returns high there, half a cycle later.
- R8: While `rst_n` is low, `hold_ack` is 0 and `bus_oe` is 0, whatever the request input. After `rst_n` rises, `bus_oe` goes high at the RST_SYNC_STAGES-th rising edge (2 by default).
- R9: While the grant is held, changes on `mc_boundary` have no effect. `hold_ack` stays high and `bus_oe` stays low for as long as the request remains.
- R10: After a grant has been released, a new request is granted with the same timing as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | External master asks for the buses |
| mc_boundary | input | 1 | Core is between machine cycles this clock |
| hold_ack | output | 1 | Grant acknowledge to the external master |
| bus_oe | output | 1 | 1: core drives address, data, read, write, memory/IO lines; 0: floated |
| core_stall | output | 1 | Core must not begin a new bus cycle |

## Verification
Some properties are checked on every clock edge. The grant is checked to start only after a boundary and only with a registered request, and it is checked to end one edge after the request is withdrawn. The lines are checked to float in the cycle after the acknowledge rises. The stall is checked to cover every edge at which the lines are floated. The exact edge positions cannot be shown by those properties, so the bench scenarios check them: the half-cycle return of the drivers on the falling edge, the reset-release latency, indifference to the boundary signal during a grant, and the repeated grant.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic {
    ARB_CORE_OWNS = 1'b0,
    ARB_GRANTED   = 1'b1
  } arb_state_e;
endpackage

// File: rtl/bha_sync_chain.sv
module bha_sync_chain #(
  parameter int STAGES = 2,
  parameter bit LOAD_ONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic [STAGES:0]   chain_ext;
  logic              in_bit;

  always_comb begin
    in_bit    = LOAD_ONE ? 1'b1 : din;
    chain_ext = {chain_q, in_bit};
    chain_d   = chain_ext[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[LAST];
endmodule

// File: rtl/bha_grant_fsm.sv
module bha_grant_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_s,
  input  logic mc_boundary,
  output logic hold_ack,
  output logic grant_now
);
  arb_state_e state_q;
  arb_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_CORE_OWNS: if (hold_s && mc_boundary) state_d = ARB_GRANTED;
      ARB_GRANTED:   if (!hold_s)               state_d = ARB_CORE_OWNS;
      default:                                  state_d = ARB_CORE_OWNS;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ARB_CORE_OWNS;
    else if (state_en) state_q <= state_d;
  end

  assign hold_ack  = (state_q == ARB_GRANTED);
  assign grant_now = (state_q == ARB_CORE_OWNS) && hold_s && mc_boundary;

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(mc_boundary)); // R2
  AST_NO_GRANT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack && !hold_s) |=> !hold_ack); // R4
  AST_RELEASE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_s) |=> !hold_ack); // R6
endmodule

// File: rtl/bha_bus_release.sv
module bha_bus_release (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_ack,
  output logic bus_oe
);
  logic float_pe_q;
  logic ack_ne_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) float_pe_q <= 1'b0;
    else        float_pe_q <= hold_ack;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ack_ne_q <= 1'b0;
    else        ack_ne_q <= hold_ack;
  end

  assign bus_oe = rst_n && !(float_pe_q && ack_ne_q);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int RST_SYNC_STAGES  = 2,
  parameter int HOLD_SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic mc_boundary,
  output logic hold_ack,
  output logic bus_oe,
  output logic core_stall
);
  logic rst_sync_n;
  logic hold_s;
  logic grant_now;

  bha_sync_chain #(.STAGES(RST_SYNC_STAGES), .LOAD_ONE(1'b1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b0), .dout(rst_sync_n)
  );

  bha_sync_chain #(.STAGES(HOLD_SYNC_STAGES), .LOAD_ONE(1'b0)) u_hold_smp (
    .clk(clk), .rst_n(rst_sync_n), .din(hold_req), .dout(hold_s)
  );

  bha_grant_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .hold_s(hold_s), .mc_boundary(mc_boundary),
    .hold_ack(hold_ack), .grant_now(grant_now)
  );

  bha_bus_release u_rel (
    .clk(clk), .rst_n(rst_sync_n), .hold_ack(hold_ack), .bus_oe(bus_oe)
  );

  assign core_stall = hold_ack || grant_now;

  AST_FLOAT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_ack) |=> !bus_oe); // R3
  AST_STALL_WHILE_FLOAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_oe |-> core_stall); // R5
  AST_DRIVE_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_ack) |-> bus_oe); // R3
endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
  localparam int CLK_P = 10;
  localparam int Q = CLK_P / 4;

  logic clk;
  logic rst_n;
  logic hold_req;
  logic mc_boundary;
  logic hold_ack;
  logic bus_oe;
  logic core_stall;
  int   n_checks;
  int   n_errors;
  bit   done;

  bus_hold_arbiter uut (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .mc_boundary(mc_boundary),
    .hold_ack(hold_ack), .bus_oe(bus_oe), .core_stall(core_stall)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic after_rise();
    @(posedge clk); #(Q);
  endtask

  task automatic after_fall();
    @(negedge clk); #(Q);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; hold_req = 1'b1; mc_boundary = 1'b1;
    #1;
    chk("R8", "ack in reset", hold_ack, 1'b0);
    chk("R8", "oe in reset", bus_oe, 1'b0);
    repeat (3) after_rise();
    chk("R8", "oe held reset", bus_oe, 1'b0);
    @(negedge clk); rst_n = 1'b1; hold_req = 1'b0;
    after_rise();
    chk("R8", "oe first edge", bus_oe, 1'b0);
    after_rise();
    chk("R8", "oe second edge", bus_oe, 1'b1);
    chk("R8", "ack after reset", hold_ack, 1'b0);
  endtask

  task automatic grant(input string tag);
    @(negedge clk); hold_req = 1'b1;
    after_rise();
    chk("R1", "ack one edge", hold_ack, 1'b0);
    chk("R5", "stall at grant edge", core_stall, 1'b1);
    after_rise();
    chk(tag, "ack two edges", hold_ack, 1'b1);
    chk("R3", "oe still driven", bus_oe, 1'b1);
    after_fall();
    chk("R3", "oe driven at fall", bus_oe, 1'b1);
    after_rise();
    chk("R3", "oe floated", bus_oe, 1'b0);
    chk("R5", "stall in grant", core_stall, 1'b1);
  endtask

  task automatic release_bus();
    @(negedge clk); hold_req = 1'b0;
    after_rise();
    chk("R6", "ack kept one edge", hold_ack, 1'b1);
    after_rise();
    chk("R6", "ack dropped", hold_ack, 1'b0);
    chk("R7", "oe low before fall", bus_oe, 1'b0);
    chk("R5", "stall cleared", core_stall, 1'b0);
    after_fall();
    chk("R7", "oe back at fall", bus_oe, 1'b1);
  endtask

  task automatic t_no_request();
    @(negedge clk); hold_req = 1'b0; mc_boundary = 1'b1;
    for (int i = 0; i < 5; i++) begin
      after_rise();
      chk("R4", "ack idle", hold_ack, 1'b0);
      chk("R4", "oe idle", bus_oe, 1'b1);
    end
  endtask

  task automatic t_wait_boundary();
    @(negedge clk); mc_boundary = 1'b0; hold_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      after_rise();
      chk("R2", "ack mid cycle", hold_ack, 1'b0);
      chk("R2", "oe mid cycle", bus_oe, 1'b1);
      chk("R5", "stall mid cycle", core_stall, 1'b0);
    end
    @(negedge clk); mc_boundary = 1'b1;
    after_rise();
    chk("R2", "ack at boundary", hold_ack, 1'b1);
    after_rise();
    chk("R3", "oe floated", bus_oe, 1'b0);
    release_bus();
  endtask

  task automatic t_ignore_boundary();
    grant("R9");
    @(negedge clk); mc_boundary = 1'b0;
    for (int i = 0; i < 3; i++) begin
      after_rise();
      chk("R9", "ack holds", hold_ack, 1'b1);
      chk("R9", "oe floated", bus_oe, 1'b0);
    end
    @(negedge clk); mc_boundary = 1'b1;
    after_rise();
    chk("R9", "ack holds", hold_ack, 1'b1);
    release_bus();
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; hold_req = 1'b0; mc_boundary = 1'b1;
    t_reset();
    t_no_request();
    grant("R1");
    release_bus();
    grant("R10");
    release_bus();
    t_wait_boundary();
    t_ignore_boundary();
    t_reset();
    grant("R10");
    release_bus();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule